// File: doc/BRIEF.md
# Ready-Latency Stream Source Adapter

This block sits between a packet producer that uses plain zero-latency valid/ready handshaking and a packet consumer whose ready output is honoured only a fixed number of cycles later (the ready latency, `READY_LATENCY`, 0 to 3). Every beat carries a 64-bit data word together with start-of-packet, end-of-packet, a 3-bit count of unused bytes, an error flag and a skip-CRC flag. All six fields travel together, and beats never change order.

A beat is accepted on the upstream side in any cycle where `in_valid` and `in_ready` are both high. `in_ready` drops only when the internal buffer is full. The buffer holds `READY_LATENCY + 2` beats. On the downstream side, when the latency is N > 0, a cycle is *eligible* when `out_ready` was high N cycles earlier. `out_valid` may be high only in eligible cycles, and every valid cycle is a transfer. A drop of `out_ready` lasting k cycles therefore pauses the stream for k cycles, starting N cycles later. When N = 0, `out_valid` does not depend on `out_ready`. The beat is held and transfers in a cycle where `out_ready` is high.

Downstream valid must stay high in every eligible cycle between SOP and EOP. To meet this, the adapter opens a packet only when that packet's EOP is already buffered or the buffer is full. The upstream producer is required to keep `in_valid` high from SOP to EOP. It may idle only between packets.

Top module: `rl_stream_adapter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high, because the buffer is empty.
- R2: For N > 0, `out_valid` is high only in cycles where `out_ready` was high N cycles earlier, and each such cycle is a transfer. For N = 0, a presented beat transfers in the cycle where `out_ready` is high, and it stays presented until then.
- R3: Beats leave in the order they entered. Data, SOP, EOP, empty count, error and skip-CRC are all unchanged.
- R4: While a packet is open and no beat moves, the output fields hold the next beat still to be transferred.
- R5: From the transfer of an SOP beat up to the transfer of its EOP beat, `out_valid` is high in every eligible cycle.
- R6: Outside a packet, an eligible cycle with a non-empty buffer presents the next SOP beat exactly when that packet's EOP beat is buffered or the buffer holds `READY_LATENCY + 2` beats.
- R7: `in_ready` is low exactly when the buffer holds `READY_LATENCY + 2` beats. An upstream beat is taken in each cycle where `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Upstream beat accepted when high |
| in_data | input | DATA_W | Upstream beat data |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | EMPTY_W | Unused bytes in the last beat |
| in_err | input | 1 | Mark packet as errored |
| in_skip_crc | input | 1 | Packet already carries CRC and padding |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | Downstream ready, honoured READY_LATENCY cycles later |
| out_data | output | DATA_W | Downstream beat data |
| out_sop | output | 1 | First beat of a packet |
| out_eop | output | 1 | Last beat of a packet |
| out_empty | output | EMPTY_W | Unused bytes in the last beat |
| out_err | output | 1 | Packet error flag |
| out_skip_crc | output | 1 | Skip-CRC flag |

## Verification
Four downstream ready patterns are applied:
- A periodic single-cycle drop shows that a one-cycle deassertion causes exactly one paused cycle, N cycles later.
- Constant ready isolates the packet-start gate.
- Random ready at three-quarters density mixes short pauses.
- Long runs of low ready push the buffer full and test both in_ready and the hold-during-pause rule.

Packet lengths include single-beat packets, where SOP and EOP fall on the same beat, and packets longer than the buffer. The single-beat packets open on the EOP condition. The long packets can open only on the full condition, which separates the two halves of R6.

// File: rtl/rlsa_pkg.sv
package rlsa_pkg;
  // Per-beat control flags, kept next to data and empty count in storage.
  typedef struct packed {
    logic sop;
    logic eop;
    logic err;
    logic skip;
  } rlsa_flags_t;

  localparam int FLAG_W = $bits(rlsa_flags_t);
endpackage

// File: rtl/rlsa_ready_pipe.sv
// Turns downstream ready into two qualifiers:
//   elig    : a beat may be presented this cycle
//   xfer_ok : a presented beat is taken this cycle
module rlsa_ready_pipe #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy,
  output logic elig,
  output logic xfer_ok
);
  generate
    if (LAT == 0) begin : g_zero
      // No latency: present freely, transfer when ready is high.
      assign elig    = 1'b1;
      assign xfer_ok = rdy;
    end else begin : g_delay
      logic [LAT:0] chain;
      assign chain[0] = rdy;
      for (genvar g = 0; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g+1] <= 1'b0;
          else        chain[g+1] <= chain[g];
        end
      end
      // Ready seen LAT cycles ago grants the slot; the slot is a transfer.
      assign elig    = chain[LAT];
      assign xfer_ok = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/rlsa_beat_fifo.sv
// Small circular beat store with occupancy count.
module rlsa_beat_fifo #(
  parameter int W     = 71,
  parameter int DEPTH = 3,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rlsa_pkt_gate.sv
// Decides when the head beat is offered downstream.
// A packet opens only once its last beat is stored or the store is full,
// and then a beat is offered in every eligible slot until its EOP leaves.
module rlsa_pkt_gate #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          elig,
  input  logic          xfer_ok,
  input  logic          fifo_empty,
  input  logic          fifo_full,
  input  logic          push,
  input  logic          push_eop,
  input  logic          head_sop,
  input  logic          head_eop,
  output logic          out_valid,
  output logic          pop,
  output logic          in_pkt,
  output logic [CW-1:0] eop_cnt
);
  logic launch_ok;

  assign launch_ok = in_pkt | (eop_cnt != '0) | fifo_full;
  assign out_valid = elig & ~fifo_empty & launch_ok;
  assign pop       = out_valid & xfer_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt  <= 1'b0;
      eop_cnt <= '0;
    end else begin
      if (pop) begin
        if (head_eop)      in_pkt <= 1'b0;
        else if (head_sop) in_pkt <= 1'b1;
      end
      case ({push & push_eop, pop & head_eop})
        2'b10:   eop_cnt <= eop_cnt + CW'(1);
        2'b01:   eop_cnt <= eop_cnt - CW'(1);
        default: eop_cnt <= eop_cnt;
      endcase
    end
  end
endmodule

// File: rtl/rl_stream_adapter.sv
module rl_stream_adapter
  import rlsa_pkg::*;
#(
  parameter int READY_LATENCY = 1,
  parameter int DATA_W        = 64,
  parameter int EMPTY_W       = 3,
  localparam int DEPTH        = READY_LATENCY + 2,
  localparam int CW           = $clog2(DEPTH + 1),
  localparam int BW           = DATA_W + EMPTY_W + FLAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               in_err,
  input  logic               in_skip_crc,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_sop,
  output logic               out_eop,
  output logic [EMPTY_W-1:0] out_empty,
  output logic               out_err,
  output logic               out_skip_crc
);
  logic          elig;
  logic          xfer_ok;
  logic          push;
  logic          pop;
  logic          fifo_full;
  logic          fifo_empty;
  logic [CW-1:0] fifo_count;
  logic [CW-1:0] eop_cnt;
  logic          in_pkt;
  logic [BW-1:0] wbeat;
  logic [BW-1:0] rbeat;
  rlsa_flags_t   wflags;
  rlsa_flags_t   rflags;

  assign in_ready = ~fifo_full;
  assign push     = in_valid & in_ready;

  always_comb begin
    wflags.sop  = in_sop;
    wflags.eop  = in_eop;
    wflags.err  = in_err;
    wflags.skip = in_skip_crc;
  end
  assign wbeat = {in_data, in_empty, wflags};

  rlsa_ready_pipe #(.LAT(READY_LATENCY)) u_rdy (
    .clk     (clk),
    .rst_n   (rst_n),
    .rdy     (out_ready),
    .elig    (elig),
    .xfer_ok (xfer_ok)
  );

  rlsa_beat_fifo #(.W(BW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .wdata (wbeat),
    .pop   (pop),
    .rdata (rbeat),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign rflags = rlsa_flags_t'(rbeat[FLAG_W-1:0]);

  rlsa_pkt_gate #(.CW(CW)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .elig       (elig),
    .xfer_ok    (xfer_ok),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .push       (push),
    .push_eop   (in_eop),
    .head_sop   (rflags.sop),
    .head_eop   (rflags.eop),
    .out_valid  (out_valid),
    .pop        (pop),
    .in_pkt     (in_pkt),
    .eop_cnt    (eop_cnt)
  );

  assign out_data     = rbeat[BW-1 -: DATA_W];
  assign out_empty    = rbeat[FLAG_W +: EMPTY_W];
  assign out_sop      = rflags.sop;
  assign out_eop      = rflags.eop;
  assign out_err      = rflags.err;
  assign out_skip_crc = rflags.skip;
endmodule

// File: rtl/rlsa_checker.sv
module rlsa_checker #(
  parameter int DATA_W  = 64,
  parameter int EMPTY_W = 3,
  parameter int DEPTH   = 3,
  parameter int CW      = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               out_valid,
  input logic [DATA_W-1:0]  out_data,
  input logic               out_sop,
  input logic               out_eop,
  input logic [EMPTY_W-1:0] out_empty,
  input logic               out_err,
  input logic               out_skip_crc,
  input logic               elig,
  input logic               xfer_ok,
  input logic               in_pkt,
  input logic [CW-1:0]      eop_cnt,
  input logic               fifo_full,
  input logic [CW-1:0]      fifo_count
);
  AST_VALID_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> elig); // R2

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !xfer_ok) |=> out_valid); // R2

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid && !xfer_ok) || (in_pkt && !out_valid)) |=>
      ($stable(out_data) && $stable(out_sop) && $stable(out_eop) &&
       $stable(out_empty) && $stable(out_err) && $stable(out_skip_crc))); // R4

  AST_GAPLESS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pkt && elig) |-> out_valid); // R5

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !in_pkt) |-> (out_sop && (eop_cnt != '0 || fifo_full))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (!in_ready && fifo_count == CW'(DEPTH))); // R7

  AST_EOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    eop_cnt <= fifo_count); // R3
endmodule

bind rl_stream_adapter rlsa_checker #(
  .DATA_W(DATA_W), .EMPTY_W(EMPTY_W), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_sop      (out_sop),
  .out_eop      (out_eop),
  .out_empty    (out_empty),
  .out_err      (out_err),
  .out_skip_crc (out_skip_crc),
  .elig         (elig),
  .xfer_ok      (xfer_ok),
  .in_pkt       (in_pkt),
  .eop_cnt      (eop_cnt),
  .fifo_full    (fifo_full),
  .fifo_count   (fifo_count)
);

// File: tb/rl_stream_adapter_tb_top.sv
module rl_stream_adapter_tb_top;
  localparam int RL    = 1;
  localparam int DW    = 64;
  localparam int EW    = 3;
  localparam int DEPTH = RL + 2;
  localparam int BW    = DW + EW + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_ready, in_sop, in_eop, in_err, in_skip_crc;
  logic [DW-1:0] in_data;
  logic [EW-1:0] in_empty;
  logic          out_valid, out_ready, out_sop, out_eop, out_err, out_skip_crc;
  logic [DW-1:0] out_data;
  logic [EW-1:0] out_empty;

  always #10 clk = ~clk; // 50 MHz

  rl_stream_adapter #(.READY_LATENCY(RL), .DATA_W(DW), .EMPTY_W(EW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_empty(in_empty),
    .in_err(in_err), .in_skip_crc(in_skip_crc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_empty(out_empty),
    .out_err(out_err), .out_skip_crc(out_skip_crc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int phase = 0;
  logic [BW-1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] pack_beat(input logic [DW-1:0] d, input logic s,
      input logic e, input logic [EW-1:0] m, input logic r, input logic k);
    return {d, m, s, e, r, k};
  endfunction

  // Ready history: hist[i] = out_ready at the (i+1)-th most recent edge.
  logic [3:0] hist;
  always @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[2:0], out_ready};
  end

  // Monitor, sampled away from the clock edge.
  int occ = 0, eopc = 0;
  bit b_inpkt = 1'b0;
  bit elig, xfer, gate;
  logic [BW-1:0] ob;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      elig = (RL == 0) ? 1'b1 : hist[(RL > 0) ? RL-1 : 0];
      xfer = out_valid && ((RL == 0) ? out_ready : 1'b1);
      ob   = pack_beat(out_data, out_sop, out_eop, out_empty, out_err, out_skip_crc);
      if (out_valid) chk(elig, "R2 valid outside eligible slot", 0, 1);
      chk(in_ready == (occ != DEPTH), "R7 in_ready vs fill", in_ready, occ != DEPTH);
      if (!b_inpkt && occ > 0 && elig) begin
        gate = (eopc > 0) || (occ == DEPTH);
        chk(out_valid == gate, "R6 packet start", out_valid, gate);
      end
      if (b_inpkt && elig) chk(out_valid, "R5 gap inside packet", out_valid, 1);
      if (b_inpkt && !out_valid && exp_q.size() > 0)
        chk(ob == exp_q[0], "R4 held beat in pause", ob, exp_q[0]);
      if (xfer) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected beat", ob, 0);
        else begin
          chk(ob == exp_q[0], "R3 beat content/order", ob, exp_q[0]);
          void'(exp_q.pop_front());
        end
        if (out_eop) b_inpkt = 1'b0;
        else if (out_sop) b_inpkt = 1'b1;
        occ--;
        if (out_eop) eopc--;
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(pack_beat(in_data, in_sop, in_eop, in_empty, in_err, in_skip_crc));
        occ++;
        if (in_eop) eopc++;
      end
    end
  end

  // Downstream ready patterns per phase.
  int rcyc = 0;
  initial begin
    out_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      rcyc++;
      case (phase)
        0: out_ready = (rcyc % 7) != 3;            // single-cycle drops
        1: out_ready = 1'b1;                       // always ready
        2: out_ready = ($urandom % 4) != 0;        // random 75%
        default: if ($urandom % 8 == 0) out_ready = ~out_ready; // long runs
      endcase
    end
  end

  task automatic send_packet(input int len);
    bit skip;
    skip = $urandom % 2;
    for (int b = 0; b < len; b++) begin
      in_valid    = 1'b1;
      in_data     = {$urandom, $urandom};
      in_sop      = (b == 0);
      in_eop      = (b == len - 1);
      in_empty    = in_eop ? EW'($urandom) : '0;
      in_err      = in_eop ? 1'($urandom) : 1'b0;
      in_skip_crc = skip;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_sop   = 1'b0;
    in_eop   = 1'b0;
    repeat ($urandom % 4) @(posedge clk);
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240605));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_sop = 1'b0; in_eop = 1'b0;
    in_empty = '0; in_err = 1'b0; in_skip_crc = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 reset out_valid", out_valid, 0);
    chk(in_ready, "R1 reset in_ready", in_ready, 1);
    @(posedge clk); #1;
    for (int ph = 0; ph < 4; ph++) begin
      phase = ph;
      for (int p = 0; p < 60; p++) begin
        if (p % 5 == 0)      send_packet(1);             // SOP and EOP together
        else if (p % 7 == 0) send_packet(2 * DEPTH + 3); // longer than the store
        else                 send_packet(1 + $urandom % 8);
      end
    end
    phase = 1;
    for (int w = 0; w < 2000 && exp_q.size() > 0; w++) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all beats delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule